// File: doc/BRIEF.md
# Global 64-bit Timer with Comparator

This block is a global timer peripheral reached through a simple register port. It keeps a 64-bit free-running count that software loads as two 32-bit halves and sets running with a control bit. One 64-bit comparator is matched against the count. When the comparator's self-advance option is on, each match adds a programmable step to the comparator, so events repeat at a fixed period. When the option is off, the comparator fires once and then waits to be reprogrammed.

The timing registers (count halves, control, comparator halves, step) take effect a fixed number of clocks after the write strobe. This models the crossing into the timer domain. As each of these writes lands, it sets its own sticky acknowledge bit, and software clears that bit by writing 1 to it. The interrupt enable, the interrupt status and the two acknowledge registers act at the write edge itself. The interrupt output is active high and is the AND of the status bit and the enable bit.

Registers are addressed by word on a 4-bit address. Reads are combinational on `rd_addr`.

Top module: `gtimer_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq` is low.
- R2: Address 0x0 loads count bits 31:0 and address 0x1 loads count bits 63:32. On the landing edge the written half is replaced, the other half is kept and the count does not advance. On every other edge the count advances by exactly 1 while running.
- R3: The control register is at address 0x2: bit 0 run, bit 1 comparator enable, bit 2 self-advance. While run is 0 the count holds its value.
- R4: Address 0x3 holds comparator bits 31:0, address 0x4 holds comparator bits 63:32, and address 0x5 holds the 32-bit step. Writes to 0x0 through 0x5 land on the third rising edge after the edge that samples the strobe.
- R5: A match is an armed and enabled comparator equal to the count. On the next edge it sets bit 0 of the status register at 0x7.
- R6: Without self-advance the comparator matches once. It is armed again only when a write to 0x2, 0x3 or 0x4 lands.
- R7: With self-advance, each match adds the step to the comparator on the same edge that sets the status, and the comparator stays armed.
- R8: Bit 0 of address 0x6 is the interrupt enable and acts at the write edge. Writing 1 to bit 0 of 0x7 clears the status at the write edge, but a match on the same edge wins. `irq` equals status AND enable.
- R9: Acknowledge bits are set on the landing edge of their write. At 0x8: bit 16 is control, bit 0 is comparator low, bit 1 is comparator high, bit 2 is step. At 0x9: bit 0 is count low, bit 1 is count high. Each bit stays set until 1 is written to its position, which clears it at the write edge; a landing on the same edge wins.
- R10: The two count halves are read live and are not latched together. A carry out of the low half shows at once in the high half.
- R11: Writes to addresses 0xA through 0xF change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Active-high comparator interrupt |

## Verification
A timing-register write sampled on rising edge k changes the register, and its acknowledge bit, on edge k+3. A match present before an edge raises the status on that edge. Enable and clear writes act on the strobe edge itself. The bench's reference model keeps every pending timing write in a queue tagged with its due edge number and updates its own state on each rising edge. It then compares `irq` and the register selected by `rd_addr` one time unit after each falling edge, when all of that edge's effects are settled. The directed timing checks peek at the falling edges before and after the due edge to pin the three-cycle latency exactly.

// File: rtl/gtimer_pkg.sv
// Package: shared widths, register map, control/acknowledge bit positions
// and the write-request type used by the global timer.
// Assumes word addressing and a single 32-bit register port.
package gtimer_pkg;
    localparam int REG_W      = 32;
    localparam int CNT_W      = 2 * REG_W;
    localparam int ADDR_W     = 4;
    localparam int SYNC_DEPTH = 3;
    localparam int N_TRACK    = 6;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_CNT_LO  = 4'h0;
    localparam addr_t A_CNT_HI  = 4'h1;
    localparam addr_t A_CTRL    = 4'h2;
    localparam addr_t A_CMP_LO  = 4'h3;
    localparam addr_t A_CMP_HI  = 4'h4;
    localparam addr_t A_STEP    = 4'h5;
    localparam addr_t A_IRQ_EN  = 4'h6;
    localparam addr_t A_IRQ_ST  = 4'h7;
    localparam addr_t A_ACK     = 4'h8;
    localparam addr_t A_CNT_ACK = 4'h9;

    localparam int CTL_RUN  = 0;
    localparam int CTL_CEN  = 1;
    localparam int CTL_AUTO = 2;

    typedef struct packed {
        logic             vld;
        addr_t            addr;
        logic [REG_W-1:0] data;
    } wreq_t;

    // True for registers that cross the synchronisation delay
    function automatic logic is_synced(addr_t a);
        return a <= A_STEP;
    endfunction

    // Acknowledge slot i belongs to this register
    function automatic addr_t track_addr(int i);
        case (i)
            0:       return A_CNT_LO;
            1:       return A_CNT_HI;
            2:       return A_CTRL;
            3:       return A_CMP_LO;
            4:       return A_CMP_HI;
            default: return A_STEP;
        endcase
    endfunction

    // Register through which acknowledge slot i is read and cleared
    function automatic addr_t track_home(int i);
        return (i < 2) ? A_CNT_ACK : A_ACK;
    endfunction

    // Bit position of acknowledge slot i inside its home register
    function automatic int track_pos(int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 16;
            3:       return 0;
            4:       return 1;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/gtimer_sync_pipe.sv
// Module: fixed-latency carrier for timing-register writes.
// A request entering on edge k leaves the last stage after edge k+STAGES-1,
// so its target register updates on edge k+STAGES. Assumes STAGES >= 1.
module gtimer_sync_pipe
    import gtimer_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic  clk,
    input  logic  rst_n,
    input  wreq_t req_i,
    output wreq_t req_o
);
    wreq_t stage_q [STAGES];

    // Shift each request one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= req_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign req_o = stage_q[STAGES-1];
endmodule

// File: rtl/gtimer_counter.sv
// Module: control register and 64-bit count.
// A landing half-write replaces that half and suppresses the step for
// that edge. Assumes at most one landing write per cycle.
module gtimer_counter
    import gtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wreq_t            apply_i,
    output logic             run_o,
    output logic             cen_o,
    output logic             auto_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [2:0]       ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ctrl_wr, lo_wr, hi_wr;

    assign ctrl_wr = apply_i.vld && (apply_i.addr == A_CTRL);
    assign lo_wr   = apply_i.vld && (apply_i.addr == A_CNT_LO);
    assign hi_wr   = apply_i.vld && (apply_i.addr == A_CNT_HI);

    // Control bits take the landing write
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= {apply_i.data[CTL_AUTO], apply_i.data[CTL_CEN],
                                     apply_i.data[CTL_RUN]};
    end

    // Count: load a half, or advance by one while running
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (lo_wr)      cnt_q <= {cnt_q[CNT_W-1:REG_W], apply_i.data};
        else if (hi_wr)      cnt_q <= {apply_i.data, cnt_q[REG_W-1:0]};
        else if (ctrl_q[0])  cnt_q <= cnt_q + 1'b1;
    end

    assign run_o  = ctrl_q[0];
    assign cen_o  = ctrl_q[1];
    assign auto_o = ctrl_q[2];
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/gtimer_compare.sv
// Module: 64-bit comparator with one-shot arming and self-advance.
// Assumes the count and control come from gtimer_counter; a landing
// comparator write takes priority over self-advance on the same edge.
module gtimer_compare
    import gtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wreq_t            apply_i,
    input  logic             cen_i,
    input  logic             auto_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic [REG_W-1:0] step_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cmp_q;
    logic [REG_W-1:0] step_q;
    logic             armed_q;
    logic             lo_wr, hi_wr, step_wr, rearm;

    assign lo_wr   = apply_i.vld && (apply_i.addr == A_CMP_LO);
    assign hi_wr   = apply_i.vld && (apply_i.addr == A_CMP_HI);
    assign step_wr = apply_i.vld && (apply_i.addr == A_STEP);
    assign rearm   = lo_wr || hi_wr || (apply_i.vld && (apply_i.addr == A_CTRL));

    assign match_o = armed_q && cen_i && (cnt_i == cmp_q);

    // Comparator value: software load or advance by the step on a match
    always_ff @(posedge clk) begin
        if (!rst_n)                 cmp_q <= '0;
        else if (lo_wr)             cmp_q <= {cmp_q[CNT_W-1:REG_W], apply_i.data};
        else if (hi_wr)             cmp_q <= {apply_i.data, cmp_q[REG_W-1:0]};
        else if (match_o && auto_i) cmp_q <= cmp_q + {{(CNT_W-REG_W){1'b0}}, step_q};
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n)       step_q <= '0;
        else if (step_wr) step_q <= apply_i.data;
    end

    // Arming: reprogramming arms, a one-shot match disarms
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed_q <= 1'b0;
        else if (rearm)              armed_q <= 1'b1;
        else if (match_o && !auto_i) armed_q <= 1'b0;
    end

    assign cmp_o  = cmp_q;
    assign step_o = step_q;
endmodule

// File: rtl/gtimer_status.sv
// Module: interrupt enable, interrupt status and sticky acknowledge bits.
// Host writes act at the strobe edge; a set on the same edge beats a clear.
module gtimer_status
    import gtimer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  wreq_t              host_i,
    input  wreq_t              apply_i,
    input  logic               match_i,
    output logic               en_o,
    output logic               stat_o,
    output logic [N_TRACK-1:0] track_o
);
    logic en_q, stat_q, stat_clr;

    assign stat_clr = host_i.vld && (host_i.addr == A_IRQ_ST) && host_i.data[0];

    // Interrupt enable follows host writes
    always_ff @(posedge clk) begin
        if (!rst_n)                                     en_q <= 1'b0;
        else if (host_i.vld && host_i.addr == A_IRQ_EN) en_q <= host_i.data[0];
    end

    // Interrupt status: set on match, write-1 clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= match_i | (stat_q & ~stat_clr);
    end

    for (genvar i = 0; i < N_TRACK; i++) begin : g_track
        logic bit_q, set_w, clr_w;
        assign set_w = apply_i.vld && (apply_i.addr == track_addr(i));
        assign clr_w = host_i.vld && (host_i.addr == track_home(i))
                       && host_i.data[track_pos(i)];
        // One sticky acknowledge bit per timing register
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= set_w | (bit_q & ~clr_w);
        end
        assign track_o[i] = bit_q;
    end

    assign en_o   = en_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/gtimer_top.sv
// Module: global 64-bit timer with one comparator.
// Timing-register writes go through a fixed-delay pipe; enable, status and
// acknowledge writes act at once. Reads are combinational.
module gtimer_top
    import gtimer_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);
    wreq_t              host_req, sync_req, apply_req;
    logic               run, cen, auto_inc, match, irq_en, irq_stat;
    logic [CNT_W-1:0]   cnt, cmp;
    logic [REG_W-1:0]   step;
    logic [N_TRACK-1:0] track;
    logic               apply_vld;
    addr_t              apply_addr;

    assign host_req = '{vld: wr_en, addr: wr_addr, data: wr_data};
    assign sync_req = '{vld: wr_en && is_synced(wr_addr), addr: wr_addr, data: wr_data};

    gtimer_sync_pipe #(.STAGES(SYNC_STAGES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .req_i(sync_req), .req_o(apply_req)
    );

    assign apply_vld  = apply_req.vld;
    assign apply_addr = apply_req.addr;

    gtimer_counter u_counter (
        .clk(clk), .rst_n(rst_n), .apply_i(apply_req),
        .run_o(run), .cen_o(cen), .auto_o(auto_inc), .cnt_o(cnt)
    );

    gtimer_compare u_compare (
        .clk(clk), .rst_n(rst_n), .apply_i(apply_req), .cen_i(cen),
        .auto_i(auto_inc), .cnt_i(cnt), .cmp_o(cmp), .step_o(step), .match_o(match)
    );

    gtimer_status u_status (
        .clk(clk), .rst_n(rst_n), .host_i(host_req), .apply_i(apply_req),
        .match_i(match), .en_o(irq_en), .stat_o(irq_stat), .track_o(track)
    );

    assign irq = irq_stat & irq_en;

    // Read mux over the register map
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CNT_LO:  rd_data = cnt[REG_W-1:0];
            A_CNT_HI:  rd_data = cnt[CNT_W-1:REG_W];
            A_CTRL:    begin
                rd_data[CTL_RUN]  = run;
                rd_data[CTL_CEN]  = cen;
                rd_data[CTL_AUTO] = auto_inc;
            end
            A_CMP_LO:  rd_data = cmp[REG_W-1:0];
            A_CMP_HI:  rd_data = cmp[CNT_W-1:REG_W];
            A_STEP:    rd_data = step;
            A_IRQ_EN:  rd_data[0] = irq_en;
            A_IRQ_ST:  rd_data[0] = irq_stat;
            A_ACK:     begin
                for (int i = 2; i < N_TRACK; i++) rd_data[track_pos(i)] = track[i];
            end
            A_CNT_ACK: begin
                for (int i = 0; i < 2; i++) rd_data[track_pos(i)] = track[i];
            end
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gtimer_checker.sv
// Module: protocol assertions for gtimer_top, attached by bind.
// Assumes synchronous active-low reset; all properties disabled in reset.
module gtimer_checker
    import gtimer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              apply_vld,
    input logic [ADDR_W-1:0] apply_addr,
    input logic              run,
    input logic              auto_inc,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [REG_W-1:0]  step,
    input logic              match,
    input logic              irq_stat,
    input logic              ack_ctrl
);
    logic cnt_land, cmp_land, rearm_land;
    assign cnt_land   = apply_vld && (apply_addr == A_CNT_LO || apply_addr == A_CNT_HI);
    assign cmp_land   = apply_vld && (apply_addr == A_CMP_LO || apply_addr == A_CMP_HI);
    assign rearm_land = cmp_land || (apply_vld && apply_addr == A_CTRL);

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_land) |=> (cnt == $past(cnt) + 1'b1));

    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_land) |=> $stable(cnt));

    assert_status_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat) |-> $past(match));

    assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !auto_inc && !rearm_land) |=> !match);

    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && auto_inc && !cmp_land) |=>
            (cmp == $past(cmp) + {{(CNT_W-REG_W){1'b0}}, $past(step)}));

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IRQ_ST && wr_data[0] && !match) |=> !irq_stat);

    assert_ack_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_ctrl) |-> $past(apply_vld && apply_addr == A_CTRL));
endmodule

bind gtimer_top gtimer_checker u_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .apply_vld(apply_vld), .apply_addr(apply_addr), .run(run), .auto_inc(auto_inc),
    .cnt(cnt), .cmp(cmp), .step(step), .match(match), .irq_stat(irq_stat),
    .ack_ctrl(track[2])
);

// File: tb/tb_gtimer_top.sv
// Bench: behavioural reference model updated on each rising edge, compared
// against irq and the selected read register after every falling edge,
// plus directed checks of latency, one-shot, periodic and clear behaviour.
module tb_gtimer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit scan    = 1'b0;

    always #4 clk = ~clk;

    gtimer_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [63:0] m_cnt, m_cmp;
    logic [31:0] m_step;
    bit m_run, m_cen, m_auto, m_armed, m_en, m_stat;
    bit [5:0] m_ack;  // 0 cnt lo, 1 cnt hi, 2 ctrl, 3 cmp lo, 4 cmp hi, 5 step
    int q_due[$];
    logic [3:0]  q_addr[$];
    logic [31:0] q_data[$];
    int cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_step = 0;
            m_run = 0; m_cen = 0; m_auto = 0; m_armed = 0; m_en = 0; m_stat = 0;
            m_ack = 0; q_due.delete(); q_addr.delete(); q_data.delete(); cyc = 0;
        end else begin
            bit mt;
            logic [63:0] n_cnt, n_cmp;
            bit n_armed, n_stat, n_en;
            bit [5:0] n_ack;
            mt = m_armed && m_cen && (m_cnt == m_cmp);
            n_cnt = m_run ? m_cnt + 1 : m_cnt;
            n_cmp = m_cmp; n_armed = m_armed; n_stat = m_stat; n_ack = m_ack; n_en = m_en;
            if (wr_en) begin
                case (wr_addr)
                    4'h6: n_en = wr_data[0];
                    4'h7: if (wr_data[0]) n_stat = 0;
                    4'h8: begin
                        if (wr_data[16]) n_ack[2] = 0;
                        if (wr_data[0])  n_ack[3] = 0;
                        if (wr_data[1])  n_ack[4] = 0;
                        if (wr_data[2])  n_ack[5] = 0;
                    end
                    4'h9: begin
                        if (wr_data[0]) n_ack[0] = 0;
                        if (wr_data[1]) n_ack[1] = 0;
                    end
                    default: ;
                endcase
            end
            if (mt) begin
                n_stat = 1;
                if (m_auto) n_cmp = m_cmp + {32'h0, m_step};
                else        n_armed = 0;
            end
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                logic [3:0] a; logic [31:0] d;
                a = q_addr.pop_front(); d = q_data.pop_front(); void'(q_due.pop_front());
                case (a)
                    4'h0: begin n_cnt = {m_cnt[63:32], d}; n_ack[0] = 1; end
                    4'h1: begin n_cnt = {d, m_cnt[31:0]}; n_ack[1] = 1; end
                    4'h2: begin m_run = d[0]; m_cen = d[1]; m_auto = d[2];
                                n_armed = 1; n_ack[2] = 1; end
                    4'h3: begin n_cmp = {m_cmp[63:32], d}; n_armed = 1; n_ack[3] = 1; end
                    4'h4: begin n_cmp = {d, m_cmp[31:0]}; n_armed = 1; n_ack[4] = 1; end
                    default: begin m_step = d; n_ack[5] = 1; end
                endcase
            end
            if (wr_en && wr_addr <= 4'h5) begin
                q_due.push_back(cyc + 3); q_addr.push_back(wr_addr); q_data.push_back(wr_data);
            end
            m_cnt = n_cnt; m_cmp = n_cmp; m_armed = n_armed; m_stat = n_stat;
            m_en = n_en; m_ack = n_ack;
            cyc++;
        end
    end

    function automatic logic [31:0] mread(logic [3:0] a);
        case (a)
            4'h0: return m_cnt[31:0];
            4'h1: return m_cnt[63:32];
            4'h2: return {29'h0, m_auto, m_cen, m_run};
            4'h3: return m_cmp[31:0];
            4'h4: return m_cmp[63:32];
            4'h5: return m_step;
            4'h6: return {31'h0, m_en};
            4'h7: return {31'h0, m_stat};
            4'h8: return {15'h0, m_ack[2], 13'h0, m_ack[5], m_ack[4], m_ack[3]};
            4'h9: return {30'h0, m_ack[1], m_ack[0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] a);
        case (a)
            4'h0, 4'h1: return "R2";
            4'h2:       return "R3";
            4'h3, 4'h4, 4'h5: return "R4";
            4'h6, 4'h7: return "R8";
            4'h8, 4'h9: return "R9";
            default:    return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (scan) rd_addr = (rd_addr == 4'hA) ? 4'h0 : rd_addr + 1'b1;
        #1;
        if (rst_n) begin
            chk("R5/R8 irq", irq, m_stat & m_en);
            chk(tag_of(rd_addr), rd_data, mread(rd_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a; #2; v = rd_data;
    endtask

    task automatic expect_rd(input string tag, input logic [3:0] a, input logic [31:0] e);
        logic [31:0] v;
        peek(a, v); chk(tag, v, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v1, v2;
        logic [63:0] tgt;
        int hits;
        idle(5); rst_n = 1; idle(1);

        // R1: reset values
        for (int a = 0; a < 10; a++) expect_rd("R1 reset", 4'(a), 32'h0);
        chk("R1 irq", irq, 1'b0);

        // R11: unmapped write ignored, read zero
        wr(4'hA, 32'hFFFF_FFFF); idle(4);
        expect_rd("R11 unmapped", 4'hA, 32'h0);
        expect_rd("R11 no ack", 4'h9, 32'h0);
        expect_rd("R11 no ack main", 4'h8, 32'h0);

        // R2/R4: three-cycle landing latency
        wr(4'h0, 32'd100);
        expect_rd("R4 not yet", 4'h0, 32'h0);
        @(negedge clk); expect_rd("R4 not yet", 4'h0, 32'h0);
        @(negedge clk); expect_rd("R4 not yet", 4'h0, 32'h0);
        @(negedge clk); expect_rd("R4 landed", 4'h0, 32'd100);
        expect_rd("R9 cnt lo ack", 4'h9, 32'h1);
        wr(4'h9, 32'h1);
        expect_rd("R9 cnt ack cleared", 4'h9, 32'h0);
        chk("R3 stopped", m_cnt, 64'd100);

        // R10/R2: rollover across the halves
        wr(4'h1, 32'h0); wr(4'h0, 32'hFFFF_FFF0); wr(4'h2, 32'h1);
        idle(30);
        expect_rd("R10 high half carried", 4'h1, 32'h1);
        peek(4'h0, v1); idle(5); peek(4'h0, v2);
        chk("R2 count rate", v2 - v1, 32'd5);

        // R5/R6: one-shot match
        tgt = m_cnt + 64'd40;
        wr(4'h4, tgt[63:32]); wr(4'h3, tgt[31:0]); wr(4'h6, 32'h1); wr(4'h2, 32'h3);
        idle(50);
        chk("R5 irq after match", irq, 1'b1);
        expect_rd("R5 status", 4'h7, 32'h1);
        wr(4'h7, 32'h1);
        expect_rd("R8 w1c", 4'h7, 32'h0);
        idle(60);
        chk("R6 no refire", irq, 1'b0);

        // R7: periodic via self-advance
        wr(4'h5, 32'd10);
        tgt = m_cnt + 64'd30;
        wr(4'h4, tgt[63:32]); wr(4'h3, tgt[31:0]); wr(4'h2, 32'h7);
        idle(40);
        hits = 0;
        repeat (100) begin
            @(negedge clk); #2;
            if (irq) begin hits++; wr_en = 1; wr_addr = 4'h7; wr_data = 32'h1; end
            else wr_en = 0;
        end
        @(negedge clk); wr_en = 0;
        n_tests++;
        if (hits < 9 || hits > 11) begin
            n_fail++;
            $display("FAIL R7 periodic: actual %0d expected 10", hits);
        end

        // R9: acknowledge bits and selective clear
        expect_rd("R9 main ack", 4'h8, 32'h0001_0007);
        wr(4'h8, 32'h0001_0000);
        expect_rd("R9 ctrl ack cleared", 4'h8, 32'h0000_0007);
        wr(4'h8, 32'h0000_0007);
        expect_rd("R9 all cleared", 4'h8, 32'h0);

        // R8: masked interrupt with pending status
        wr(4'h6, 32'h0); idle(25);
        chk("R8 masked irq", irq, 1'b0);
        expect_rd("R8 pending status", 4'h7, 32'h1);
        wr(4'h2, 32'h1); idle(5);
        wr(4'h7, 32'h1);
        expect_rd("R8 cleared", 4'h7, 32'h0);

        // R3: stop holds the count
        wr(4'h2, 32'h0); idle(4);
        peek(4'h0, v1); idle(5); peek(4'h0, v2);
        chk("R3 hold", v2, v1);

        // Free scan against the model
        wr(4'h6, 32'h1); wr(4'h2, 32'h7);
        scan = 1; idle(80); scan = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule